// File: doc/BRIEF.md
# Branch and Next-Address Unit

This block works out where instruction fetch goes next. It takes the address of the current instruction, the whole instruction word, and the values already read for the instruction's first and second source registers. From these it produces the following fetch address, plus a request to write a return address into the link register. The block is purely combinational and sits between register read and the program-counter register of a simple in-order pipeline.

Four kinds of control flow are handled. The first is ten compare-and-branch forms. Equality and inequality form one pair. The other eight are ordered compares, each in a two's-complement form and a plain magnitude form. The remaining kinds are a PC-relative jump, a jump through a register, and a linking version of each jump. All relative displacements count in 32-bit words and are added to the address of the following instruction, not to the current one. Any opcode outside the control set simply steps to the next word.

The register-indirect linking jump takes its target from the first operand value exactly as it arrives. The link write happens later, in the register file. So when that operand was read from the link register itself, the jump still goes to the value that register held before the write.

Top module: `nextpc_gen`

## Requirements
- R1: For every opcode (instruction bits 31:26) outside the fourteen values 0x30 to 0x3D, the next address is the current address plus 4, modulo 2^32, and link_we_o is 0.
- R2: A taken conditional branch takes instruction bits 15:0 as a signed word displacement. It multiplies that by 4 and adds it to the current address plus 4, modulo 2^32.
- R3: A conditional branch whose condition is false yields the current address plus 4.
- R4: Opcode 0x30 branches when the first operand equals the second, and 0x31 branches when they differ.
- R5: The signed codes compare the first operand against the second as two's-complement numbers. 0x32 branches when it is less, 0x34 when less or equal, 0x36 when greater, and 0x38 when greater or equal.
- R6: The unsigned codes compare the same way as unsigned magnitudes. 0x33 branches when the first is less, 0x35 when less or equal, 0x37 when greater, and 0x39 when greater or equal.
- R7: Opcode 0x3A jumps to the current address plus 4, plus four times the signed value of instruction bits 25:0, modulo 2^32, and link_we_o is 0.
- R8: Opcode 0x3C sets the next address to the first operand value with every bit kept, including the two low bits, and link_we_o is 0.
- R9: Opcode 0x3B jumps to the same target as R7, drives link_we_o to 1, and drives link_data_o with the current address plus 4.
- R10: Opcode 0x3D drives link_we_o to 1 and link_data_o with the current address plus 4. Its next address is the first operand value as presented, which is the pre-write value when that operand is the link register.
- R11: link_we_o is 1 only for opcodes 0x3B and 0x3D, and it is 0 for all branch codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| opa_i | input | 32 | Value read for the first source register |
| opb_i | input | 32 | Value read for the second source register |
| next_pc_o | output | 32 | Address of the instruction to fetch next |
| link_we_o | output | 1 | Request to write link_data_o into the link register |
| link_data_o | output | 32 | Return address (current address plus 4) |

## Verification
The embedded checks assume that the inputs are settled, two-state values within each evaluation, because the block holds no state and judges every combination on its own. The bench keeps to this by changing the inputs only just after a rising clock edge and reading the outputs at the falling edge. It sweeps all 64 opcodes against every ordered pair from a set of operand values chosen to straddle the sign and magnitude boundaries. Addresses and displacement fields come from a shift-register sequence, with extreme displacements and an address near the top of the space forced at regular intervals to exercise wrap-around.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int OPC_LSB = INSTR_W - OPC_W;

  // control-flow opcode map
  localparam logic [OPC_W-1:0] OP_BR_EQ   = 6'h30;
  localparam logic [OPC_W-1:0] OP_BR_NE   = 6'h31;
  localparam logic [OPC_W-1:0] OP_BR_LT   = 6'h32;
  localparam logic [OPC_W-1:0] OP_BR_LTU  = 6'h33;
  localparam logic [OPC_W-1:0] OP_BR_LE   = 6'h34;
  localparam logic [OPC_W-1:0] OP_BR_LEU  = 6'h35;
  localparam logic [OPC_W-1:0] OP_BR_GT   = 6'h36;
  localparam logic [OPC_W-1:0] OP_BR_GTU  = 6'h37;
  localparam logic [OPC_W-1:0] OP_BR_GE   = 6'h38;
  localparam logic [OPC_W-1:0] OP_BR_GEU  = 6'h39;
  localparam logic [OPC_W-1:0] OP_JREL    = 6'h3A;
  localparam logic [OPC_W-1:0] OP_JREL_LK = 6'h3B;
  localparam logic [OPC_W-1:0] OP_JREG    = 6'h3C;
  localparam logic [OPC_W-1:0] OP_JREG_LK = 6'h3D;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_BRANCH,
    FLOW_REL,
    FLOW_REG
  } flow_e;

  typedef enum logic [3:0] {
    CMP_EQ,
    CMP_NE,
    CMP_LT,
    CMP_LTU,
    CMP_LE,
    CMP_LEU,
    CMP_GT,
    CMP_GTU,
    CMP_GE,
    CMP_GEU
  } cmp_e;

endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
  import nextpc_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output flow_e            flow_o,
  output cmp_e             cmp_o,
  output logic             link_o
);

  always_comb begin
    flow_o = FLOW_SEQ;
    cmp_o  = CMP_EQ;
    link_o = 1'b0;
    case (opc_i)
      OP_BR_EQ:   begin flow_o = FLOW_BRANCH; cmp_o = CMP_EQ;  end
      OP_BR_NE:   begin flow_o = FLOW_BRANCH; cmp_o = CMP_NE;  end
      OP_BR_LT:   begin flow_o = FLOW_BRANCH; cmp_o = CMP_LT;  end
      OP_BR_LTU:  begin flow_o = FLOW_BRANCH; cmp_o = CMP_LTU; end
      OP_BR_LE:   begin flow_o = FLOW_BRANCH; cmp_o = CMP_LE;  end
      OP_BR_LEU:  begin flow_o = FLOW_BRANCH; cmp_o = CMP_LEU; end
      OP_BR_GT:   begin flow_o = FLOW_BRANCH; cmp_o = CMP_GT;  end
      OP_BR_GTU:  begin flow_o = FLOW_BRANCH; cmp_o = CMP_GTU; end
      OP_BR_GE:   begin flow_o = FLOW_BRANCH; cmp_o = CMP_GE;  end
      OP_BR_GEU:  begin flow_o = FLOW_BRANCH; cmp_o = CMP_GEU; end
      OP_JREL:    begin flow_o = FLOW_REL; end
      OP_JREL_LK: begin flow_o = FLOW_REL; link_o = 1'b1; end
      OP_JREG:    begin flow_o = FLOW_REG; end
      OP_JREG_LK: begin flow_o = FLOW_REG; link_o = 1'b1; end
      default:    begin flow_o = FLOW_SEQ; end
    endcase
  end

  // R11: a link request only ever accompanies a jump
  always_comb begin
    a_r11_link_with_jump: assert (!link_o || flow_o == FLOW_REL || flow_o == FLOW_REG)
      else $error("link request outside jump class");
  end

endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  cmp_e            sel_i,
  output logic            hit_o
);

  localparam int MSB = XLEN - 1;
  localparam int UNS = 0;
  localparam int SGN = 1;

  logic [XLEN:0] diff;
  logic          borrow;
  logic          same;
  logic [1:0]    less;
  logic [1:0]    more;

  // one subtraction serves both interpretations
  assign diff   = {1'b0, a_i} - {1'b0, b_i};
  assign borrow = diff[XLEN];
  assign same   = (diff[MSB:0] == '0);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_kind
      if (g == SGN) begin : g_signed
        assign less[g] = borrow ^ (a_i[MSB] ^ b_i[MSB]);
      end else begin : g_unsigned
        assign less[g] = borrow;
      end
      assign more[g] = ~less[g] & ~same;
    end
  endgenerate

  always_comb begin
    case (sel_i)
      CMP_EQ:  hit_o = same;
      CMP_NE:  hit_o = ~same;
      CMP_LT:  hit_o = less[SGN];
      CMP_LTU: hit_o = less[UNS];
      CMP_LE:  hit_o = less[SGN] | same;
      CMP_LEU: hit_o = less[UNS] | same;
      CMP_GT:  hit_o = more[SGN];
      CMP_GTU: hit_o = more[UNS];
      CMP_GE:  hit_o = ~less[SGN];
      CMP_GEU: hit_o = ~less[UNS];
      default: hit_o = 1'b0;
    endcase
  end

  always_comb begin
    // R4: zero difference means the operands match
    a_r4_same_means_equal: assert (same == (a_i == b_i))
      else $error("equality flag disagrees with operands");
    // R5: exactly one signed relation holds
    a_r5_signed_trichotomy: assert ($onehot({less[SGN], more[SGN], same}))
      else $error("signed relations not exclusive");
    // R6: exactly one unsigned relation holds
    a_r6_unsigned_trichotomy: assert ($onehot({less[UNS], more[UNS], same}))
      else $error("unsigned relations not exclusive");
  end

endmodule

// File: rtl/nextpc_addr.sv
module nextpc_addr #(
  parameter int XLEN   = 32,
  parameter int BOFF_W = 16,
  parameter int JOFF_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [BOFF_W-1:0] boff_i,
  input  logic [JOFF_W-1:0] joff_i,
  output logic [XLEN-1:0]   seq_o,
  output logic [XLEN-1:0]   br_tgt_o,
  output logic [XLEN-1:0]   rel_tgt_o
);

  localparam int WORD_SH = 2;
  localparam int BPAD    = XLEN - BOFF_W - WORD_SH;
  localparam int JPAD    = XLEN - JOFF_W - WORD_SH;
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << WORD_SH);

  function automatic logic [XLEN-1:0] scale_short(input logic [BOFF_W-1:0] f);
    return {{BPAD{f[BOFF_W-1]}}, f, {WORD_SH{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] scale_long(input logic [JOFF_W-1:0] f);
    return {{JPAD{f[JOFF_W-1]}}, f, {WORD_SH{1'b0}}};
  endfunction

  assign seq_o     = pc_i + STEP;
  assign br_tgt_o  = seq_o + scale_short(boff_i);
  assign rel_tgt_o = seq_o + scale_long(joff_i);

  always_comb begin
    // R2: a branch moves by whole words from the sequential address
    a_r2_branch_word_step: assert (((br_tgt_o - seq_o) & (STEP - 1'b1)) == '0)
      else $error("branch target not word-stepped");
    // R7: a relative jump moves by whole words from the sequential address
    a_r7_jump_word_step: assert (((rel_tgt_o - seq_o) & (STEP - 1'b1)) == '0)
      else $error("jump target not word-stepped");
  end

endmodule

// File: rtl/nextpc_gen.sv
module nextpc_gen
  import nextpc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int BOFF_W = 16,
  parameter int JOFF_W = 26
) (
  input  logic [XLEN-1:0]    pc_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    opa_i,
  input  logic [XLEN-1:0]    opb_i,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               link_we_o,
  output logic [XLEN-1:0]    link_data_o
);

  logic [OPC_W-1:0] opc;
  flow_e            flow;
  cmp_e             cmp_sel;
  logic             link_req;
  logic             cond_hit;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  br_tgt;
  logic [XLEN-1:0]  rel_tgt;

  assign opc = instr_i[INSTR_W-1:OPC_LSB];

  nextpc_decode u_decode (
    .opc_i  (opc),
    .flow_o (flow),
    .cmp_o  (cmp_sel),
    .link_o (link_req)
  );

  nextpc_cond #(.XLEN(XLEN)) u_cond (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sel_i (cmp_sel),
    .hit_o (cond_hit)
  );

  nextpc_addr #(.XLEN(XLEN), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W)) u_addr (
    .pc_i      (pc_i),
    .boff_i    (instr_i[BOFF_W-1:0]),
    .joff_i    (instr_i[JOFF_W-1:0]),
    .seq_o     (seq_pc),
    .br_tgt_o  (br_tgt),
    .rel_tgt_o (rel_tgt)
  );

  // target taken from the operand as read: the link write comes later
  always_comb begin
    case (flow)
      FLOW_BRANCH: next_pc_o = cond_hit ? br_tgt : seq_pc;
      FLOW_REL:    next_pc_o = rel_tgt;
      FLOW_REG:    next_pc_o = opa_i;
      default:     next_pc_o = seq_pc;
    endcase
  end

  assign link_we_o   = link_req;
  assign link_data_o = seq_pc;

  always_comb begin
    // R1: non-control code steps one word and never links
    a_r1_sequential_step: assert (flow != FLOW_SEQ || (next_pc_o == pc_i + XLEN'(4) && !link_we_o))
      else $error("sequential step wrong");
    // R3: false condition falls through
    a_r3_fall_through: assert (!(flow == FLOW_BRANCH && !cond_hit) || next_pc_o == pc_i + XLEN'(4))
      else $error("not-taken branch moved");
    // R8, R10: register jumps land on the operand untouched
    a_r8_register_target: assert (flow != FLOW_REG || next_pc_o == opa_i)
      else $error("register jump target altered");
    // R9, R10: return address is the following instruction
    a_r9_link_value: assert (!link_we_o || link_data_o == pc_i + XLEN'(4))
      else $error("link value wrong");
    // R11: branches never request a link write
    a_r11_branch_no_link: assert (flow != FLOW_BRANCH || !link_we_o)
      else $error("branch requested link");
  end

endmodule

// File: tb/nextpc_gen_bench.sv
module nextpc_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVAL = 8;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic [31:0] instr_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [31:0] next_pc_o;
  logic        link_we_o;
  logic [31:0] link_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nextpc_gen u_nextpc_gen (
    .pc_i        (pc_i),
    .instr_i     (instr_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .next_pc_o   (next_pc_o),
    .link_we_o   (link_we_o),
    .link_data_o (link_data_o)
  );

  function automatic logic [31:0] pick(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0002;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h8000_0001;
      6: return 32'hFFFF_FFFF;
      default: return 32'h5A5A_0F0F;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input bit taken);
    if (op == 6'h30 || op == 6'h31) return taken ? "R2/R4" : "R3/R4";
    if (op >= 6'h32 && op <= 6'h39 && !op[0]) return taken ? "R2/R5" : "R3/R5";
    if (op >= 6'h32 && op <= 6'h39 &&  op[0]) return taken ? "R2/R6" : "R3/R6";
    if (op == 6'h3A) return "R7";
    if (op == 6'h3B) return "R9";
    if (op == 6'h3C) return "R8";
    if (op == 6'h3D) return "R10";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (op %h pc %h a %h b %h)",
               tag, act, exp, instr_i[31:26], pc_i, opa_i, opb_i);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic apply_and_check(input logic [31:0] pc, input logic [31:0] ins,
                                 input logic [31:0] a, input logic [31:0] b);
    logic [5:0]  op;
    logic [31:0] seq;
    logic [31:0] exp_next;
    bit          taken;
    bit          links;
    int          bo;
    int          jo;
    @(posedge clk);
    pc_i = pc; instr_i = ins; opa_i = a; opb_i = b;
    op  = ins[31:26];
    seq = pc + 32'd4;
    bo  = int'($signed(ins[15:0]));
    jo  = int'($signed(ins[25:0]));
    taken = 1'b0;
    case (op)
      6'h30: taken = (a == b);
      6'h31: taken = (a != b);
      6'h32: taken = ($signed(a) <  $signed(b));
      6'h33: taken = (a <  b);
      6'h34: taken = ($signed(a) <= $signed(b));
      6'h35: taken = (a <= b);
      6'h36: taken = ($signed(a) >  $signed(b));
      6'h37: taken = (a >  b);
      6'h38: taken = ($signed(a) >= $signed(b));
      6'h39: taken = (a >= b);
      default: taken = 1'b0;
    endcase
    links = (op == 6'h3B || op == 6'h3D);
    if (op >= 6'h30 && op <= 6'h39)
      exp_next = taken ? seq + 32'(bo * 4) : seq;
    else if (op == 6'h3A || op == 6'h3B)
      exp_next = seq + 32'(jo * 4);
    else if (op == 6'h3C || op == 6'h3D)
      exp_next = a;
    else
      exp_next = seq;
    @(negedge clk);
    check(tag_of(op, taken), next_pc_o, exp_next);
    check(links ? "R9/R10 link enable" : "R11 link enable", {31'd0, link_we_o}, {31'd0, links});
    if (links) check("R9/R10 link value", link_data_o, seq);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin : stim
    logic [31:0] lfsr;
    logic [31:0] pcv;
    logic [25:0] low;
    int          vec;
    lfsr = 32'hACE1_2468;
    vec  = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs step to address 4 without linking (R1)
    apply_and_check(32'h0, 32'h0, 32'h0, 32'h0);
    // R10: first operand read from the link register keeps its old value
    apply_and_check(32'h0000_1000, {6'h3D, 26'h3E0_0000}, 32'h0000_2222, 32'h0);
    // R8: low address bits survive a register jump
    apply_and_check(32'h0000_0040, {6'h3C, 26'h0}, 32'h1234_5677, 32'h0);
    // R2/R7 wrap-around at the top of the space
    apply_and_check(32'hFFFF_FFFC, {6'h30, 10'h0, 16'h0001}, 32'h5, 32'h5);
    apply_and_check(32'h0000_0000, {6'h3A, 26'h3FF_FFFE}, 32'h0, 32'h0);
    apply_and_check(32'hFFFF_FFF8, {6'h3B, 26'h000_0010}, 32'h0, 32'h0);
    for (int op = 0; op < 64; op++) begin
      for (int i = 0; i < NVAL; i++) begin
        for (int j = 0; j < NVAL; j++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          pcv  = {lfsr[29:0], 2'b00};
          low  = lfsr[31:6];
          case (vec % 8)
            1: low[15:0] = 16'h8000;
            3: low[15:0] = 16'h7FFF;
            5: low = 26'h200_0000;
            6: low = 26'h1FF_FFFF;
            7: pcv = 32'hFFFF_FFFC;
            default: ;
          endcase
          apply_and_check(pcv, {6'(op), low}, pick(i), pick(j));
          vec++;
        end
      end
    end
    summary();
  end

endmodule